// File: doc/BRIEF.md
# Four-Bit Up/Down Counting Stage with Carry and Borrow Chaining

This block is a four-bit counter with two separate request inputs: one asks for an increment and the other for a decrement. Both requests are plain levels sampled by the system clock. Only the rising transition of each counts, so a request held high advances the count once. A load strobe copies a four-bit preset into the count, and an asynchronous clear returns the count to zero at once.

When the count leaves its top state going up, the stage emits a one-cycle carry pulse. When it leaves zero going down, it emits a one-cycle borrow pulse. Wiring a stage's carry to the increment request of the next stage, and its borrow to the decrement request, builds wider counters out of identical stages. A parameter selects the count range: binary mode (sixteen states, top state 15) or decade mode (top state 9).

Top module: `updn_stage`

## Requirements
- R1: While `clr` is high, `count` is 0 and `carry` and `borrow` are 0. Raising `clr` forces this without waiting for a clock edge.
- R2: A rising transition of `up_req` (seen low at one clock edge, high at the next) increments `count` at that edge. In binary mode the count passes through all 16 states, and 15 goes to 0.
- R3: A rising transition of `dn_req` decrements `count` at the clock edge where it is first seen high.
- R4: Holding `up_req` or `dn_req` high over many cycles produces exactly one count.
- R5: At a clock edge with `load` high, `count` takes the value of `preset`. Any request edge seen at that same edge is discarded.
- R6: `carry` is high for exactly the one cycle in which `count` has just wrapped upward from the top state to 0. The top state is 15 in binary mode and 9 in decade mode.
- R7: `borrow` is high for exactly the one cycle in which `count` has just wrapped downward from 0 to the top state.
- R8: When rising transitions of both requests are seen at the same edge, only the decrement takes place.
- R9: In decade mode, an up-count from a loaded value above 9 steps to the next value modulo 16 with no carry. A down-count from such a value decrements it by one with no borrow.
- R10: Two stages chained through carry and borrow count as one eight-bit binary counter in binary mode, and as a two-digit decimal counter (00 to 99) in decade mode. The upper stage follows the lower one cycle after each carry or borrow.
- R11: With no request edge and `load` low, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all requests are sampled on its rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| up_req | input | 1 | Increment request level; each rising transition counts once |
| dn_req | input | 1 | Decrement request level; each rising transition counts once |
| load | input | 1 | Synchronous preset strobe, takes priority over counting |
| preset | input | 4 | Value loaded into the count |
| count | output | 4 | Current count |
| carry | output | 1 | One-cycle pulse after an upward wrap to 0 |
| borrow | output | 1 | One-cycle pulse after a downward wrap to the top state |

## Verification
The bench builds two chains at the same time from the same stimulus. One chain is two stages with `DECADE` cleared, and the other is two stages with `DECADE` set. The binary chain makes the 255-to-0 and 0-to-255 rollovers through the upper stage reachable. The decade chain reaches 99-to-00 and 00-to-99, the preset values above 9 that step modulo 16 without a carry, and the borrow into the top digit. Because both chains see identical edges, every load, clear, held request and simultaneous request is checked in both ranges.

// File: rtl/updn_pkg.sv
package updn_pkg;
    // Width of one counting stage.
    parameter int CNT_W = 4;

    // What a stage does at the next clock edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DN   = 2'd3
    } step_op_e;

    // All registered state of a stage except the request history.
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             carry;
        logic             borrow;
    } stage_state_t;
endpackage

// File: rtl/updn_edge.sv
// Samples N request levels and flags each low-to-high transition.
module updn_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) prev_q <= '0;
        else     prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~prev_q[i];
    end
endmodule

// File: rtl/updn_arb.sv
// Fixed priority: load beats a decrement, which beats an increment.
module updn_arb
    import updn_pkg::*;
(
    input  logic     load,
    input  logic     up_rise,
    input  logic     dn_rise,
    output step_op_e op
);
    always_comb begin
        if (load)         op = OP_LOAD;
        else if (dn_rise) op = OP_DN;
        else if (up_rise) op = OP_UP;
        else              op = OP_HOLD;
    end
endmodule

// File: rtl/updn_step.sv
// Next-count arithmetic for one stage, binary or decade range.
module updn_step
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  step_op_e         op,
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap_up,
    output logic             wrap_dn
);
    localparam int               TOP_I = DECADE ? 9 : (1 << CNT_W) - 1;
    localparam logic [CNT_W-1:0] TOP   = CNT_W'(TOP_I);

    always_comb begin
        nxt     = cur;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        unique case (op)
            OP_LOAD: nxt = preset;
            OP_UP: begin
                if (cur == TOP) begin
                    nxt     = '0;
                    wrap_up = 1'b1;
                end else begin
                    nxt = cur + 1'b1;  // above TOP in decade mode: plain modulo-16 step
                end
            end
            OP_DN: begin
                if (cur == '0) begin
                    nxt     = TOP;
                    wrap_dn = 1'b1;
                end else begin
                    nxt = cur - 1'b1;
                end
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             up_req,
    input  logic             dn_req,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             carry,
    output logic             borrow
);
    logic [1:0]       rise;
    logic             up_rise, dn_rise;
    step_op_e         op;
    logic [CNT_W-1:0] nxt;
    logic             wrap_up, wrap_dn;
    stage_state_t     st_d, st_q;

    updn_edge #(.N(2)) u_edge (
        .clk  (clk),
        .clr  (clr),
        .lvl  ({dn_req, up_req}),
        .rise (rise)
    );

    assign up_rise = rise[0];
    assign dn_rise = rise[1];

    updn_arb u_arb (
        .load    (load),
        .up_rise (up_rise),
        .dn_rise (dn_rise),
        .op      (op)
    );

    updn_step #(.DECADE(DECADE)) u_step (
        .op      (op),
        .cur     (st_q.count),
        .preset  (preset),
        .nxt     (nxt),
        .wrap_up (wrap_up),
        .wrap_dn (wrap_dn)
    );

    always_comb begin
        st_d        = st_q;
        st_d.count  = nxt;
        st_d.carry  = wrap_up;
        st_d.borrow = wrap_dn;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    assign count  = st_q.count;
    assign carry  = st_q.carry;
    assign borrow = st_q.borrow;
endmodule

// File: rtl/updn_stage_chk.sv
module updn_stage_chk
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input logic             clk,
    input logic             clr,
    input logic             load,
    input logic [CNT_W-1:0] preset,
    input logic [CNT_W-1:0] count,
    input logic             carry,
    input logic             borrow,
    input logic             up_rise,
    input logic             dn_rise
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(DECADE ? 9 : (1 << CNT_W) - 1);

    // High once a clock edge has been taken with clear released.
    logic armed_q;
    always_ff @(posedge clk or posedge clr) begin
        if (clr) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    p_clear_r1: assert property (@(posedge clk)
        (clr && $past(clr)) |-> (count == '0 && !carry && !borrow));

    p_carry_wrap_r6: assert property (@(posedge clk) disable iff (clr)
        carry |-> (count == '0));

    p_borrow_wrap_r7: assert property (@(posedge clk) disable iff (clr)
        borrow |-> (count == TOP));

    p_no_dual_pulse_r6: assert property (@(posedge clk) disable iff (clr)
        !(carry && borrow));

    p_load_r5: assert property (@(posedge clk) disable iff (clr)
        (armed_q && $past(load)) |-> (count == $past(preset)));

    p_down_wins_r8: assert property (@(posedge clk) disable iff (clr)
        (armed_q && $past(!load && up_rise && dn_rise)) |->
        (($past(count) == '0) ? (count == TOP) : (count == $past(count) - 1'b1)));

    p_hold_r11: assert property (@(posedge clk) disable iff (clr)
        (armed_q && $past(!load && !up_rise && !dn_rise)) |-> $stable(count));
endmodule

bind updn_stage updn_stage_chk #(.DECADE(DECADE)) u_chk (
    .clk     (clk),
    .clr     (clr),
    .load    (load),
    .preset  (preset),
    .count   (count),
    .carry   (carry),
    .borrow  (borrow),
    .up_rise (up_rise),
    .dn_rise (dn_rise)
);

// File: tb/sim_updn_stage.sv
`timescale 1ns/1ps
module sim_updn_stage;
    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       up = 1'b0, dn = 1'b0, load = 1'b0;
    logic [3:0] b_plo = '0, b_phi = '0, d_plo = '0, d_phi = '0;

    logic [3:0] b_lo, b_hi, d_lo, d_hi;
    logic       b_c0, b_b0, b_c1, b_b1, d_c0, d_b0, d_c1, d_b1;

    always #2 clk = ~clk;  // 250 MHz

    // Binary chain: u0 low nibble, u1 high nibble.
    updn_stage #(.DECADE(1'b0)) u0 (.clk(clk), .clr(clr), .up_req(up), .dn_req(dn), .load(load),
        .preset(b_plo), .count(b_lo), .carry(b_c0), .borrow(b_b0));
    updn_stage #(.DECADE(1'b0)) u1 (.clk(clk), .clr(clr), .up_req(b_c0), .dn_req(b_b0), .load(load),
        .preset(b_phi), .count(b_hi), .carry(b_c1), .borrow(b_b1));
    // Decade chain: d0 units, d1 tens.
    updn_stage #(.DECADE(1'b1)) d0 (.clk(clk), .clr(clr), .up_req(up), .dn_req(dn), .load(load),
        .preset(d_plo), .count(d_lo), .carry(d_c0), .borrow(d_b0));
    updn_stage #(.DECADE(1'b1)) d1 (.clk(clk), .clr(clr), .up_req(d_c0), .dn_req(d_b0), .load(load),
        .preset(d_phi), .count(d_hi), .carry(d_c1), .borrow(d_b1));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] bin;
        logic [7:0] dec;
        int         rid;
    } exp_t;
    exp_t sb[$];

    // Reference model state.
    logic [3:0] m_bl = '0, m_bh = '0, m_dl = '0, m_dh = '0;

    task automatic check(input int rid, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %0h expected %0h", rid, act, exp);
        end
    endtask

    function automatic void step_up(inout logic [3:0] lo, inout logic [3:0] hi, input logic [3:0] top);
        if (lo == top) begin
            lo = 4'd0;
            hi = (hi == top) ? 4'd0 : hi + 4'd1;
        end else begin
            lo = lo + 4'd1;
        end
    endfunction

    function automatic void step_dn(inout logic [3:0] lo, inout logic [3:0] hi, input logic [3:0] top);
        if (lo == 4'd0) begin
            lo = top;
            hi = (hi == 4'd0) ? top : hi - 4'd1;
        end else begin
            lo = lo - 4'd1;
        end
    endfunction

    function automatic void model_up();
        step_up(m_bl, m_bh, 4'd15);
        step_up(m_dl, m_dh, 4'd9);
    endfunction

    function automatic void model_dn();
        step_dn(m_bl, m_bh, 4'd15);
        step_dn(m_dl, m_dh, 4'd9);
    endfunction

    // Let carries settle, then queue the expectation for the monitor.
    task automatic expect_now(input int rid);
        repeat (3) @(negedge clk);
        @(posedge clk);
        sb.push_back('{bin: {m_bh, m_bl}, dec: {m_dh, m_dl}, rid: rid});
    endtask

    task automatic pulse(input bit u, input bit d, input int rid);
        @(negedge clk); up = u; dn = d;
        @(negedge clk); up = 1'b0; dn = 1'b0;
        if (d) model_dn(); else if (u) model_up();
        expect_now(rid);
    endtask

    task automatic preload(input logic [7:0] bv, input logic [7:0] dv, input int rid);
        @(negedge clk);
        b_plo = bv[3:0]; b_phi = bv[7:4]; d_plo = dv[3:0]; d_phi = dv[7:4];
        load = 1'b1;
        @(negedge clk); load = 1'b0;
        m_bl = bv[3:0]; m_bh = bv[7:4]; m_dl = dv[3:0]; m_dh = dv[7:4];
        expect_now(rid);
    endtask

    // Monitor: compares every queued expectation at a falling edge.
    always begin
        @(negedge clk);
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.rid, {b_hi, b_lo}, e.bin);
            check(e.rid, {d_hi, d_lo}, e.dec);
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while clear is held.
        check(1, {b_hi, b_lo, d_hi, d_lo, b_c0, b_b0, d_c0, d_b0}, '0);
        clr = 1'b0;
        @(negedge clk);

        // R2, R10: counting up through several nibble and digit carries.
        for (int i = 0; i < 20; i++) pulse(1'b1, 1'b0, 2);
        // R3: counting down back past zero into both top rollovers (R10).
        for (int i = 0; i < 23; i++) pulse(1'b0, 1'b1, 3);

        // R6: carry pulse timing at the low stage, upper follows a cycle later.
        preload(8'h3F, 8'h59, 5);
        @(negedge clk); up = 1'b1;
        @(negedge clk); up = 1'b0;
        check(6, {b_lo, b_c0, b_hi}, {4'h0, 1'b1, 4'h3});
        check(6, {d_lo, d_c0, d_hi}, {4'h0, 1'b1, 4'h5});
        @(negedge clk);
        check(6, {b_c0, b_hi}, {1'b0, 4'h4});  // R10
        check(6, {d_c0, d_hi}, {1'b0, 4'h6});
        m_bl = 4'h0; m_bh = 4'h4; m_dl = 4'h0; m_dh = 4'h6;

        // R7: borrow pulse timing.
        @(negedge clk); dn = 1'b1;
        @(negedge clk); dn = 1'b0;
        check(7, {b_lo, b_b0, b_hi}, {4'hF, 1'b1, 4'h4});
        check(7, {d_lo, d_b0, d_hi}, {4'h9, 1'b1, 4'h6});
        @(negedge clk);
        check(7, {b_b0, b_hi}, {1'b0, 4'h3});
        check(7, {d_b0, d_hi}, {1'b0, 4'h5});
        model_dn();

        // R10: full-range rollovers of both chains.
        preload(8'hFF, 8'h99, 5);
        pulse(1'b1, 1'b0, 10);
        pulse(1'b0, 1'b1, 10);

        // R8: simultaneous edges, down wins (also from zero).
        preload(8'h40, 8'h40, 5);
        pulse(1'b1, 1'b1, 8);
        pulse(1'b1, 1'b1, 8);

        // R4: a held request counts once.
        @(negedge clk); up = 1'b1;
        repeat (6) @(negedge clk);
        up = 1'b0;
        model_up();
        expect_now(4);
        @(negedge clk); dn = 1'b1;
        repeat (5) @(negedge clk);
        dn = 1'b0;
        model_dn();
        expect_now(4);

        // R11: idle cycles leave the count alone.
        repeat (8) @(negedge clk);
        expect_now(11);

        // R5: a request edge coincident with load is discarded.
        @(negedge clk);
        b_plo = 4'h7; b_phi = 4'hA; d_plo = 4'h2; d_phi = 4'h8;
        load = 1'b1; up = 1'b1;
        @(negedge clk); load = 1'b0; up = 1'b0;
        m_bl = 4'h7; m_bh = 4'hA; m_dl = 4'h2; m_dh = 4'h8;
        expect_now(5);

        // R9: decade stage loaded above nine steps modulo 16 without carry.
        preload(8'h0C, 8'h3C, 9);
        pulse(1'b1, 1'b0, 9);   // dec 3D
        preload(8'h0F, 8'h2F, 9);
        pulse(1'b1, 1'b0, 9);   // dec 20, no carry into tens
        @(negedge clk);
        check(9, {d_c0, d_hi, d_lo}, {1'b0, 4'h2, 4'h0});
        preload(8'h00, 8'h1B, 9);
        pulse(1'b0, 1'b1, 9);   // dec 1A, no borrow
        pulse(1'b1, 1'b0, 9);   // back to 1B
        pulse(1'b1, 1'b0, 9);   // 1C

        // R1: asynchronous clear between clock edges.
        @(negedge clk);
        #1 clr = 1'b1;
        #0.5;
        check(1, {b_hi, b_lo, d_hi, d_lo}, 16'h0);
        check(1, {b_c0, b_b0, b_c1, b_b1, d_c0, d_b0, d_c1, d_b1}, 8'h0);
        @(negedge clk);
        clr = 1'b0;
        m_bl = 0; m_bh = 0; m_dl = 0; m_dh = 0;
        pulse(1'b1, 1'b0, 2);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule